// File: doc/BRIEF.md
# Clock-Select Register Bank with Update Strobe

This block holds the control words for a group of clock-source selectors. Each selector owns one 32-bit word that carries a source-select field and a gate bit. Software reaches the word at three addresses. A plain address replaces the whole word. An OR alias turns on only the bits written as 1. A bit-clear alias turns off only the bits written as 1. With the two aliases, separate agents can change single bits without a read-modify-write race.

A change to the select field stays pending. It reaches the `sel_o` output only when software writes 1 to that selector's bit in a shared update register. The gate bit is different: it drives the clock-enable output directly. If an update finds a pending code that is out of range, the applied code is kept and a sticky per-selector error flag is raised. Software clears that flag by writing 1 to it.

The intended software sequence for a source change has three steps:
1. Clear the select field through the bit-clear alias.
2. Write the new code through the OR alias.
3. Pulse the update bit.

The clock multiplexers themselves are outside the block.

Top module: `clksel_bank`

Address map with the default parameters:
- Selector k has its words at k*16 + {0, 4, 8}, which are the plain word, the OR alias and the bit-clear alias.
- The update register is at byte 0x40.
- The error register is at byte 0x44.

## Requirements
- R1: A write to a selector's plain address (k*16) replaces its whole word. A read at the plain, OR or bit-clear address returns the stored word.
- R2: A write to the OR alias (k*16+4) sets every word bit written as 1 and leaves the bits written as 0 unchanged.
- R3: A write to the bit-clear alias (k*16+8) clears every word bit written as 1 and leaves the bits written as 0 unchanged.
- R4: `clk_en_o[k]` is the inverse of word bit 31 (1 = gated). It changes in the cycle after the write edge, with no update pulse.
- R5: `sel_o` slice k (`sel_o[3k+2:3k]`) changes only as the result of an update pulse for selector k. Pending field changes in word bits 6:4 alone leave it unchanged.
- R6: Writing the update register (byte 0x40) with bit k set copies the pending field of selector k into `sel_o` slice k. The copy takes effect on the clock edge after the write edge. Several bits may be set at once, and selectors whose bit is 0 are unaffected.
- R7: The update register always reads as 0.
- R8: An update that finds a pending code of 5 or more (at least NUM_SRC) keeps the previous applied code and sets error bit k. The error bit is seen on `err_o[k]` and at byte 0x44, bit k.
- R9: Error bits are sticky and cleared by writing 1 to them at byte 0x44. If a new error and a clear hit the same bit in the same cycle, the new error wins.
- R10: After reset all words read 0, `sel_o` is 0, `clk_en_o` is all ones and `err_o` is 0.
- R11: When an update is applied in the same cycle that a write changes the word, the applied code is the field value from before that write.
- R12: Unmapped or misaligned addresses read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle as the request |
| sel_o | output | NUM_SEL*SEL_W | Applied select code per selector |
| clk_en_o | output | NUM_SEL | Clock enable per selector |
| err_o | output | NUM_SEL | Sticky invalid-update flags |

## Verification
Two events can land in the same cycle: an update that is being applied, and a register write. In the first case, the bench issues a plain write to a selector immediately after its update write. The apply step and the new word then share one edge, and the test passes only if `sel_o` shows the earlier pending code while a read returns the newer word. In the second case, an update with an invalid code is followed immediately by a write-1 to the same error bit. The flag must still be set after both edges.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned SLOT_BYTES = 16;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_PLAIN = 2'd1,
    ACC_SET   = 2'd2,
    ACC_CLR   = 2'd3
  } alias_e;

  function automatic logic [WORD_W-1:0] merge_word(alias_e kind,
                                                  logic [WORD_W-1:0] cur,
                                                  logic [WORD_W-1:0] wr);
    case (kind)
      ACC_PLAIN: merge_word = wr;
      ACC_SET:   merge_word = cur | wr;
      ACC_CLR:   merge_word = cur & ~wr;
      default:   merge_word = cur;
    endcase
  endfunction
endpackage

// File: rtl/clksel_decode.sv
module clksel_decode
  import clksel_pkg::*;
#(
  parameter int unsigned NUM_SEL = 4,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_SEL-1:0] slot_hit_o,
  output alias_e             kind_o,
  output logic               upd_hit_o,
  output logic               err_hit_o
);
  localparam int unsigned SLOT_SH  = $clog2(SLOT_BYTES);
  localparam int unsigned IDX_W    = ADDR_W - SLOT_SH;
  localparam int unsigned UPD_BYTE = NUM_SEL * SLOT_BYTES;
  localparam int unsigned ERR_BYTE = UPD_BYTE + 4;

  logic [IDX_W-1:0] slot_idx;
  logic             aligned;

  assign slot_idx = addr_i[ADDR_W-1:SLOT_SH];
  assign aligned  = (addr_i[1:0] == 2'b00);

  always_comb begin
    case (addr_i[3:2])
      2'd0:    kind_o = ACC_PLAIN;
      2'd1:    kind_o = ACC_SET;
      2'd2:    kind_o = ACC_CLR;
      default: kind_o = ACC_NONE;
    endcase
  end

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_hit
    assign slot_hit_o[k] = aligned && (kind_o != ACC_NONE) &&
                           (slot_idx == IDX_W'(k));
  end

  assign upd_hit_o = (addr_i == ADDR_W'(UPD_BYTE));
  assign err_hit_o = (addr_i == ADDR_W'(ERR_BYTE));
endmodule

// File: rtl/clksel_cfg_word.sv
module clksel_cfg_word
  import clksel_pkg::*;
#(
  parameter int unsigned SEL_LSB  = 4,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned GATE_BIT = 31,
  parameter int unsigned NUM_SRC  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  alias_e            kind_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              apply_i,
  output logic [WORD_W-1:0] word_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              en_o,
  output logic              bad_o
);
  logic [WORD_W-1:0] word_q;
  logic [SEL_W-1:0]  sel_q;
  logic [SEL_W-1:0]  pend;

  assign pend  = word_q[SEL_LSB +: SEL_W];
  // apply always sees the word as it stood before any write on the same edge
  assign bad_o = apply_i && (32'(pend) >= NUM_SRC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      sel_q  <= '0;
    end else begin
      if (wr_i) word_q <= merge_word(kind_i, word_q, wdata_i);
      if (apply_i && !bad_o) sel_q <= pend;
    end
  end

  assign word_o = word_q;
  assign sel_o  = sel_q;
  assign en_o   = ~word_q[GATE_BIT];
endmodule

// File: rtl/clksel_upd_ctrl.sv
module clksel_upd_ctrl #(
  parameter int unsigned NUM_SEL = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_wr_i,
  input  logic               err_wr_i,
  input  logic [NUM_SEL-1:0] wbits_i,
  input  logic [NUM_SEL-1:0] bad_i,
  output logic [NUM_SEL-1:0] apply_o,
  output logic [NUM_SEL-1:0] err_o
);
  logic [NUM_SEL-1:0] apply_q;
  logic [NUM_SEL-1:0] err_q;
  logic [NUM_SEL-1:0] clr_mask;

  assign clr_mask = err_wr_i ? wbits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      apply_q <= '0;
      err_q   <= '0;
    end else begin
      apply_q <= upd_wr_i ? wbits_i : '0;
      // a fresh error outranks a clear on the same edge
      err_q   <= (err_q & ~clr_mask) | bad_i;
    end
  end

  assign apply_o = apply_q;
  assign err_o   = err_q;
endmodule

// File: rtl/clksel_bank.sv
module clksel_bank
  import clksel_pkg::*;
#(
  parameter int unsigned NUM_SEL  = 4,
  parameter int unsigned NUM_SRC  = 5,
  parameter int unsigned SEL_LSB  = 4,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned GATE_BIT = 31,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [WORD_W-1:0]        wdata_i,
  output logic [WORD_W-1:0]        rdata_o,
  output logic [NUM_SEL*SEL_W-1:0] sel_o,
  output logic [NUM_SEL-1:0]       clk_en_o,
  output logic [NUM_SEL-1:0]       err_o
);
  logic [NUM_SEL-1:0] slot_hit;
  alias_e             kind;
  logic               upd_hit, err_hit;
  logic               wr_en;
  logic [NUM_SEL-1:0] apply, bad;
  logic [WORD_W-1:0]  word [NUM_SEL];
  logic [WORD_W-1:0]  rd_mux;

  assign wr_en = req_i && we_i;

  clksel_decode #(.NUM_SEL(NUM_SEL), .ADDR_W(ADDR_W)) i_decode (
    .addr_i     (addr_i),
    .slot_hit_o (slot_hit),
    .kind_o     (kind),
    .upd_hit_o  (upd_hit),
    .err_hit_o  (err_hit)
  );

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_sel
    clksel_cfg_word #(
      .SEL_LSB (SEL_LSB),
      .SEL_W   (SEL_W),
      .GATE_BIT(GATE_BIT),
      .NUM_SRC (NUM_SRC)
    ) i_word (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_en && slot_hit[k]),
      .kind_i  (kind),
      .wdata_i (wdata_i),
      .apply_i (apply[k]),
      .word_o  (word[k]),
      .sel_o   (sel_o[k*SEL_W +: SEL_W]),
      .en_o    (clk_en_o[k]),
      .bad_o   (bad[k])
    );
  end

  clksel_upd_ctrl #(.NUM_SEL(NUM_SEL)) i_upd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_wr_i (wr_en && upd_hit),
    .err_wr_i (wr_en && err_hit),
    .wbits_i  (wdata_i[NUM_SEL-1:0]),
    .bad_i    (bad),
    .apply_o  (apply),
    .err_o    (err_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_SEL; k++) begin
      if (slot_hit[k]) rd_mux = word[k];
    end
    if (err_hit) rd_mux = WORD_W'(err_o);
  end

  assign rdata_o = (req_i && !we_i) ? rd_mux : '0;
endmodule

// File: rtl/clksel_bank_chk.sv
module clksel_bank_chk #(
  parameter int unsigned NUM_SEL = 4,
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned ADDR_W  = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_i,
  input logic                     we_i,
  input logic [ADDR_W-1:0]        addr_i,
  input logic [NUM_SEL-1:0]       wd_low_i,
  input logic                     gate_wd_i,
  input logic [31:0]              rdata_o,
  input logic [NUM_SEL*SEL_W-1:0] sel_o,
  input logic [NUM_SEL-1:0]       clk_en_o,
  input logic [NUM_SEL-1:0]       err_o
);
  localparam int unsigned UPD_BYTE = NUM_SEL * 16;
  localparam int unsigned ERR_BYTE = UPD_BYTE + 4;

  logic upd_wr, err_wr, upd_rd;
  assign upd_wr = req_i && we_i && (addr_i == ADDR_W'(UPD_BYTE));
  assign err_wr = req_i && we_i && (addr_i == ADDR_W'(ERR_BYTE));
  assign upd_rd = req_i && !we_i && (addr_i == ADDR_W'(UPD_BYTE));

  assert_upd_reads_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_rd |-> (rdata_o == 32'd0));

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_chk
    logic plain_wr;
    assign plain_wr = req_i && we_i && (addr_i == ADDR_W'(k * 16));

    assert_sel_needs_update_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(upd_wr && wd_low_i[k], 2) |-> $stable(sel_o[k*SEL_W +: SEL_W]));

    assert_sel_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      32'(sel_o[k*SEL_W +: SEL_W]) < NUM_SRC);

    assert_gate_direct_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      plain_wr |=> (clk_en_o[k] == !$past(gate_wd_i)));

    assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(err_o[k]) |-> $past(err_wr && wd_low_i[k]));
  end
endmodule

bind clksel_bank clksel_bank_chk #(
  .NUM_SEL(NUM_SEL), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wd_low_i (wdata_i[NUM_SEL-1:0]),
  .gate_wd_i(wdata_i[GATE_BIT]),
  .rdata_o  (rdata_o),
  .sel_o    (sel_o),
  .clk_en_o (clk_en_o),
  .err_o    (err_o)
);

// File: tb/test_clksel_bank.sv
module test_clksel_bank;
  localparam int NUM_SEL = 4;
  localparam int SEL_W   = 3;
  localparam int N_VEC   = 28;
  // op: 0 write, 1 read-compare, 2 idle then sel_o compare, 3 clk_en_o compare
  localparam logic [77:0] VECS [N_VEC] = '{
    {2'd0, 8'h00, 32'h0000_0030, 32'h0,          4'd1},  // R1
    {2'd1, 8'h00, 32'h0,          32'h0000_0030, 4'd1},  // R1
    {2'd1, 8'h04, 32'h0,          32'h0000_0030, 4'd1},  // R1
    {2'd1, 8'h08, 32'h0,          32'h0000_0030, 4'd1},  // R1
    {2'd2, 8'h00, 32'h0,          32'h0000_0000, 4'd5},  // R5
    {2'd0, 8'h40, 32'h0000_0001, 32'h0,          4'd6},  // R6
    {2'd2, 8'h00, 32'h0,          32'h0000_0003, 4'd6},  // R6
    {2'd0, 8'h14, 32'h0000_0020, 32'h0,          4'd2},  // R2
    {2'd0, 8'h14, 32'h8000_0000, 32'h0,          4'd2},  // R2
    {2'd1, 8'h10, 32'h0,          32'h8000_0020, 4'd2},  // R2
    {2'd3, 8'h00, 32'h0,          32'h0000_000D, 4'd4},  // R4
    {2'd0, 8'h18, 32'h0000_0070, 32'h0,          4'd3},  // R3
    {2'd1, 8'h10, 32'h0,          32'h8000_0000, 4'd3},  // R3
    {2'd0, 8'h18, 32'h8000_0000, 32'h0,          4'd3},  // R3
    {2'd1, 8'h10, 32'h0,          32'h0000_0000, 4'd3},  // R3
    {2'd3, 8'h00, 32'h0,          32'h0000_000F, 4'd4},  // R4
    {2'd0, 8'h14, 32'h0000_0040, 32'h0,          4'd2},  // R2
    {2'd0, 8'h24, 32'h0000_0010, 32'h0,          4'd2},  // R2
    {2'd2, 8'h00, 32'h0,          32'h0000_0003, 4'd5},  // R5
    {2'd0, 8'h40, 32'h0000_0006, 32'h0,          4'd6},  // R6
    {2'd2, 8'h00, 32'h0,          32'h0000_0063, 4'd6},  // R6
    {2'd1, 8'h40, 32'h0,          32'h0000_0000, 4'd7},  // R7
    {2'd1, 8'h0C, 32'h0,          32'h0000_0000, 4'd12}, // R12
    {2'd0, 8'h3C, 32'hFFFF_FFFF, 32'h0,          4'd12}, // R12
    {2'd1, 8'h30, 32'h0,          32'h0000_0000, 4'd12}, // R12
    {2'd1, 8'h48, 32'h0,          32'h0000_0000, 4'd12}, // R12
    {2'd1, 8'h01, 32'h0,          32'h0000_0000, 4'd12}, // R12
    {2'd3, 8'h00, 32'h0,          32'h0000_000F, 4'd12}  // R12
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NUM_SEL*SEL_W-1:0] sel;
  logic [NUM_SEL-1:0] clk_en, err;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clksel_bank i_clksel_bank (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sel_o(sel), .clk_en_o(clk_en), .err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(sel == '0, "R10 sel_o", 32'(sel), 32'h0);
    chk(clk_en == 4'hF, "R10 clk_en_o", 32'(clk_en), 32'hF);
    chk(err == '0, "R10 err_o", 32'(err), 32'h0);
    bus_rd(8'h20, r);
    chk(r == 32'h0, "R10 word read", r, 32'h0);

    for (int i = 0; i < N_VEC; i++) begin
      logic [1:0]  op;
      logic [7:0]  va;
      logic [31:0] vd, ve;
      logic [3:0]  vr;
      {op, va, vd, ve, vr} = VECS[i];
      case (op)
        2'd0: bus_wr(va, vd);
        2'd1: begin
          bus_rd(va, r);
          chk(r == ve, $sformatf("R%0d vec%0d read", vr, i), r, ve);
        end
        2'd2: begin
          @(negedge clk);
          chk(32'(sel) == ve, $sformatf("R%0d vec%0d sel", vr, i), 32'(sel), ve);
        end
        default: chk(32'(clk_en) == ve, $sformatf("R%0d vec%0d en", vr, i), 32'(clk_en), ve);
      endcase
    end

    // R11: config write lands on the same edge as the apply step
    bus_wr(8'h00, 32'h0000_0020);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 8'h40; wdata = 32'h1;
    @(negedge clk); addr = 8'h00; wdata = 32'h0000_0010;
    @(negedge clk); req = 1'b0; we = 1'b0;
    @(negedge clk);
    chk(sel == 12'h062, "R11 applied pre-write code", 32'(sel), 32'h062);
    bus_rd(8'h00, r);
    chk(r == 32'h10, "R11 word holds new write", r, 32'h10);

    // R8: invalid pending code keeps applied value, flags error
    bus_wr(8'h30, 32'h0000_0060);
    bus_wr(8'h40, 32'h8);
    @(negedge clk);
    chk(sel == 12'h062, "R8 sel kept", 32'(sel), 32'h062);
    chk(err == 4'h8, "R8 err_o", 32'(err), 32'h8);
    bus_rd(8'h44, r);
    chk(r == 32'h8, "R8 err read", r, 32'h8);

    // R9: write-1 clears
    bus_wr(8'h44, 32'h8);
    chk(err == 4'h0, "R9 cleared", 32'(err), 32'h0);

    // R9: new error and clear on the same edge, error wins
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 8'h40; wdata = 32'h8;
    @(negedge clk); addr = 8'h44; wdata = 32'h8;
    @(negedge clk); req = 1'b0; we = 1'b0;
    chk(err == 4'h8, "R9 set beats clear", 32'(err), 32'h8);
    bus_wr(8'h44, 32'hF);
    chk(err == 4'h0, "R9 clear after collision", 32'(err), 32'h0);
    chk(sel == 12'h062, "R8 sel kept after second invalid", 32'(sel), 32'h062);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule